// File: doc/BRIEF.md
# Serial Input Clock Absence Detector

This block supervises the bit clock of several sigma-delta input channels and reports each channel whose clock has stopped. Every channel has a serial clock input and a serial data input. Both pass through a two-stage synchronizer into the system clock domain. In SPI format the detector watches edges on the clock input. In Manchester format it watches transitions on the data line instead, because that line carries the embedded clock. A shared divider turns the system clock into a reference period. Each channel counts reference periods since its last input edge. A channel whose count reaches eight is declared clock-absent.

Each channel keeps a sticky absence flag. The flag is forced high while the channel is switched off. It also stays high until the channel has seen its first input edge, which is how the channel synchronizes. A write-one-to-clear request drops the flag for one cycle. After that the flag follows the live absence condition again. Per-channel detection and interrupt enables gate a single combined interrupt. When the reference clock is not taken from the system clock, absence detection is suppressed.

Top module: `sckmon_top`

## Requirements
- R1: After reset every channel's flag reads 1 and the interrupt output reads 0.
- R2: The interrupt output is the OR over channels of flag AND detection enable AND interrupt enable; clearing a channel's interrupt enable removes its contribution while its flag stays 1.
- R3: A clear request on a synchronized, enabled channel makes its flag 0 on the following cycle; if the absence condition is still true, the flag returns to 1 one cycle later.
- R4: While a channel's enable is 0, its flag is 1 on every following cycle.
- R5: A channel becomes synchronized on the first edge of its monitored input while enabled, and it loses synchronization when disabled; while unsynchronized, its flag stays 1 and clear requests have no effect.
- R6: With format select 0 (SPI), the flag of a detection-enabled channel is set once eight reference periods pass with no edge on its clock input; the flag stays 0 while edges keep arriving within that window.
- R7: The reference period is (divider value + 1) system clock cycles, and the absence window scales with it.
- R8: With the source select at 0 (not the system clock), no absence sets a flag.
- R9: With format select 1 (Manchester), the channel synchronizes and restarts its window on data-line transitions only; clock-input edges are ignored.
- R10: With the detection enable at 0, a cleared flag stays 0 however long the input stays quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | NCH | Per-channel enable |
| det_en | input | NCH | Per-channel absence detection enable |
| irq_en | input | NCH | Per-channel interrupt enable |
| clr_req | input | NCH | Per-channel write-one-to-clear pulse for the flag |
| fmt_manch | input | 1 | Input format: 0 SPI clock, 1 Manchester data |
| ref_from_sys | input | 1 | 1 when the reference clock comes from the system clock |
| ref_div | input | DIV_W | Reference period minus one, in system clock cycles |
| ser_clk | input | NCH | Asynchronous serial clock per channel |
| ser_data | input | NCH | Asynchronous serial data per channel |
| abs_flag | output | NCH | Sticky clock-absence flags |
| irq | output | 1 | Combined absence interrupt |

## Verification
An input edge reaches the channel's synchronizer and edge detector after three rising clock edges. A clear request or a change in channel enable shows on the flag one edge after it is sampled. The refreshed set after a clear follows one edge later. The interrupt follows the flag and its enables in the same cycle. The absence window is bounded from both sides. The bench checks that the flag is still 0 at well under eight reference periods after the last edge. It also checks that the flag is 1 well past nine periods, so the divider phase cannot move a result across a check. Every expectation is queued just after a falling edge with the inputs held still. It is compared at the next falling edge, which places it exactly one register stage after the stimulus.

// File: rtl/sckmon_pkg.sv
// Package: shared constants and types of the clock absence detector.
// Assumes: nothing beyond the standard.
package sckmon_pkg;
    // Reference periods without an input edge that declare the clock absent.
    localparam int ABS_LIMIT = 8;
    localparam int CNT_W     = $clog2(ABS_LIMIT + 1);

    typedef enum logic {
        FMT_SPI   = 1'b0,
        FMT_MANCH = 1'b1
    } fmt_e;
endpackage

// File: rtl/sckmon_refdiv.sv
// Module: reference period generator. Emits a one-cycle tick every
// (div + 1) system clock cycles. Assumes div may change at any time; a
// running count above the new value wraps at once.
module sckmon_refdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    assign tick = (phase >= div);

    // Free-running phase counter that wraps at the divider value.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    // R7: a tick is followed by a gap unless the period is one cycle.
    a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/sckmon_chan.sv
// Module: one channel of the absence detector. Synchronizes the serial
// clock and data, picks the monitored input by format, tracks
// synchronization, counts reference ticks since the last edge and keeps
// the sticky flag. Assumes the serial inputs are asynchronous to clk.
module sckmon_chan
    import sckmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic det,
    input  logic clr,
    input  fmt_e fmt,
    input  logic src_sys,
    input  logic tick,
    input  logic ser_clk,
    input  logic ser_data,
    output logic flag
);
    logic [2:0]       clk_q;
    logic [2:0]       dat_q;
    logic             edge_seen;
    logic             synced;
    logic [CNT_W-1:0] quiet;
    logic             absent;

    // Two synchronizer stages plus one history stage per input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= '0;
            dat_q <= '0;
        end else begin
            clk_q <= {clk_q[1:0], ser_clk};
            dat_q <= {dat_q[1:0], ser_data};
        end
    end

    assign edge_seen = (fmt == FMT_MANCH) ? (dat_q[2] ^ dat_q[1])
                                          : (clk_q[2] ^ clk_q[1]);

    // Synchronization: set by the first edge while enabled, lost on disable.
    always_ff @(posedge clk) begin
        if (!rst_n)         synced <= 1'b0;
        else if (!en)       synced <= 1'b0;
        else if (edge_seen) synced <= 1'b1;
    end

    // Reference ticks since the last edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   quiet <= '0;
        else if (!en || edge_seen)                    quiet <= '0;
        else if (tick && quiet != CNT_W'(ABS_LIMIT))  quiet <= quiet + 1'b1;
    end

    assign absent = det && src_sys && (quiet == CNT_W'(ABS_LIMIT));

    // Sticky flag: forced, cleared on request, or set by absence.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b1;
        else if (!en || !synced)   flag <= 1'b1;
        else if (clr)              flag <= 1'b0;
        else if (absent)           flag <= 1'b1;
    end

    // R4: a disabled channel shows its flag set.
    a_r4_disabled_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> flag);
    // R5: an unsynchronized channel keeps its flag set.
    a_r5_unsynced_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |=> flag);
    // R3: a clear on a live channel takes effect on the next cycle.
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (en && synced && clr) |=> !flag);
    // R6: an edge restarts the window.
    a_r6_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && edge_seen) |=> (quiet == '0));
    // R6: the window count never passes the limit.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        quiet <= CNT_W'(ABS_LIMIT));
endmodule

// File: rtl/sckmon_top.sv
// Module: top of the serial input clock absence detector. Shares one
// reference divider among NCH channels and merges their gated flags into
// one interrupt. Assumes all control inputs are synchronous to clk.
module sckmon_top
    import sckmon_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ch_en,
    input  logic [NCH-1:0]   det_en,
    input  logic [NCH-1:0]   irq_en,
    input  logic [NCH-1:0]   clr_req,
    input  logic             fmt_manch,
    input  logic             ref_from_sys,
    input  logic [DIV_W-1:0] ref_div,
    input  logic [NCH-1:0]   ser_clk,
    input  logic [NCH-1:0]   ser_data,
    output logic [NCH-1:0]   abs_flag,
    output logic             irq
);
    logic tick;
    fmt_e fmt;

    assign fmt = fmt_e'(fmt_manch);

    sckmon_refdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (ref_div),
        .tick  (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        sckmon_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[i]),
            .det      (det_en[i]),
            .clr      (clr_req[i]),
            .fmt      (fmt),
            .src_sys  (ref_from_sys),
            .tick     (tick),
            .ser_clk  (ser_clk[i]),
            .ser_data (ser_data[i]),
            .flag     (abs_flag[i])
        );
    end

    // Combined interrupt of enabled, flagged channels.
    always_comb irq = |(abs_flag & det_en & irq_en);

    // R2: no interrupt while every interrupt enable is low.
    a_r2_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
    // R1: flags come out of reset set.
    a_r1_reset_flags: assert property (@(posedge clk)
        !rst_n |=> (abs_flag == {NCH{1'b1}}));
endmodule

// File: tb/sim_sckmon_top.sv
module sim_sckmon_top;
    localparam int NCH    = 2;
    localparam int DIV_W  = 8;
    localparam time TCLK  = 10ns;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH-1:0]   ch_en, det_en, irq_en, clr_req, ser_clk, ser_data;
    logic             fmt_manch, ref_from_sys;
    logic [DIV_W-1:0] ref_div;
    logic [NCH-1:0]   abs_flag;
    logic             irq;

    always #(TCLK/2) clk = ~clk;

    sckmon_top #(.NCH(NCH), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .det_en(det_en),
        .irq_en(irq_en), .clr_req(clr_req), .fmt_manch(fmt_manch),
        .ref_from_sys(ref_from_sys), .ref_div(ref_div),
        .ser_clk(ser_clk), .ser_data(ser_data),
        .abs_flag(abs_flag), .irq(irq)
    );

    typedef struct {
        logic [NCH-1:0] mask;
        logic [NCH-1:0] val;
        bit             chk_irq;
        bit             irq_v;
        string          tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Monitor: compare one queued expectation per falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (((abs_flag ^ e.val) & e.mask) != '0) begin
                n_bad++;
                $display("FAIL %s flags actual=%b expected=%b (mask %b)",
                         e.tag, abs_flag, e.val, e.mask);
            end
            if (e.chk_irq && irq !== e.irq_v) begin
                n_bad++;
                $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.irq_v);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Driver: queue an expectation, then hold inputs until it is compared.
    task automatic expect_flags(input logic [NCH-1:0] m, input logic [NCH-1:0] v,
                                input bit ci, input bit iv, input string tag);
        exp_t e;
        e.mask = m; e.val = v; e.chk_irq = ci; e.irq_v = iv; e.tag = tag;
        q.push_back(e);
        step(1);
    endtask

    task automatic pulse_clr(input logic [NCH-1:0] m);
        clr_req = m;
        step(1);
        clr_req = '0;
    endtask

    initial begin
        rst_n = 1'b0; ch_en = '0; det_en = '0; irq_en = '0; clr_req = '0;
        ser_clk = '0; ser_data = '0; fmt_manch = 1'b0; ref_from_sys = 1'b1;
        ref_div = 8'd3;
        step(3);
        expect_flags(2'b11, 2'b11, 1, 0, "R1 in reset");
        rst_n = 1'b1;
        expect_flags(2'b11, 2'b11, 1, 0, "R1 after reset");

        ch_en = 2'b11;
        step(10);
        pulse_clr(2'b11);
        expect_flags(2'b11, 2'b11, 0, 0, "R5 clear ignored unsynced");

        ser_clk[0] = ~ser_clk[0];
        step(5);
        pulse_clr(2'b01);
        expect_flags(2'b01, 2'b00, 0, 0, "R3 clear after sync");
        step(40);
        expect_flags(2'b01, 2'b00, 1, 0, "R10 detection off stays clear");

        ser_clk[0] = ~ser_clk[0];
        step(4);
        det_en = 2'b01; irq_en = 2'b01;
        for (int k = 0; k < 8; k++) begin
            step(8);
            ser_clk[0] = ~ser_clk[0];
            expect_flags(2'b01, 2'b00, 1, 0, "R6 edges keep flag clear");
        end
        step(24);
        expect_flags(2'b01, 2'b00, 1, 0, "R6 under eight periods");
        step(20);
        expect_flags(2'b01, 2'b01, 1, 1, "R6 absence after eight periods, R2 irq");

        irq_en = 2'b00;
        expect_flags(2'b01, 2'b01, 1, 0, "R2 interrupt enable off");
        irq_en = 2'b01;
        expect_flags(2'b01, 2'b01, 1, 1, "R2 interrupt enable on");

        clr_req = 2'b01;
        expect_flags(2'b01, 2'b00, 0, 0, "R3 clear drops flag");
        clr_req = '0;
        expect_flags(2'b01, 2'b01, 0, 0, "R3 refresh re-sets flag");

        ser_clk[0] = ~ser_clk[0];
        step(4);
        pulse_clr(2'b01);
        ref_from_sys = 1'b0;
        step(50);
        expect_flags(2'b01, 2'b00, 1, 0, "R8 suppressed on other source");
        ser_clk[0] = ~ser_clk[0];
        step(4);
        ref_from_sys = 1'b1;

        ch_en = 2'b10;
        expect_flags(2'b01, 2'b01, 0, 0, "R4 disabled forces flag");
        ch_en = 2'b11;
        step(3);
        pulse_clr(2'b01);
        expect_flags(2'b01, 2'b01, 0, 0, "R5 sync lost on disable");
        ser_clk[0] = ~ser_clk[0];
        step(4);
        pulse_clr(2'b01);
        expect_flags(2'b01, 2'b00, 0, 0, "R5 resync on first edge");

        fmt_manch = 1'b1;
        ser_clk[1] = ~ser_clk[1];
        step(5);
        pulse_clr(2'b10);
        expect_flags(2'b10, 2'b10, 0, 0, "R9 clock edge ignored in Manchester");
        ser_data[1] = ~ser_data[1];
        step(5);
        pulse_clr(2'b10);
        expect_flags(2'b10, 2'b00, 0, 0, "R9 data transition synchronizes");

        fmt_manch = 1'b0;
        ref_div = 8'd7;
        ser_clk[0] = ~ser_clk[0];
        step(4);
        pulse_clr(2'b01);
        expect_flags(2'b01, 2'b00, 0, 0, "R7 cleared with longer period");
        step(40);
        expect_flags(2'b01, 2'b00, 0, 0, "R7 window scales with divider");
        step(40);
        expect_flags(2'b01, 2'b01, 0, 0, "R7 absence after longer window");

        step(2);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule